// File: doc/BRIEF.md
# Completion Packet Integrity Guard

This block watches a packet stream of completion data where a beat is accepted when the source's valid and the sink's ready are both high. For every packet it reaches one verdict: forward the packet or nullify it. Two faults lead to nullification. One is a byte parity mismatch: each data byte comes with a sideband bit that must give the byte odd parity. The other is a user abort raised on any beat after the first, which stays in effect until the packet ends.

One cycle after the end beat of a packet is accepted, the block pulses a done flag together with a nullify flag and two error flags. The error flags keep the parity cause and the abort cause apart. It also raises a separate pulse when the source misuses the abort signal. Parity checking is controlled by a static enable input. The block only observes: it never stalls or alters the stream.

Top module: `cpl_integrity_guard`

## Requirements
- R1: With `par_chk_en` high, sideband bit i must equal the odd parity of data byte i (bits 8i+7..8i), which is 1 when that byte has an even number of ones. Any mismatch on an accepted beat makes the packet's verdict show `pkt_nullify`=1 and `pkt_par_err`=1.
- R2: With `par_chk_en` low, the parity sideband has no effect on the verdict.
- R3: A parity fault on any accepted beat of a packet, including a beat before the end beat, is carried to that packet's verdict.
- R4: An abort seen on an accepted beat stays in effect for the rest of the packet even after the source drops it. The verdict then shows `pkt_nullify`=1 and `pkt_abort_err`=1.
- R5: An abort raised on the end beat itself, as when the packet is cut short, also nullifies the packet.
- R6: Abort and parity are sampled only on accepted beats (valid and ready both high). Values present while ready is low have no effect.
- R7: The verdict flags `pkt_done`, `pkt_nullify`, `pkt_par_err` and `pkt_abort_err` are high for exactly the one cycle after the end beat (`beat_last`=1) is accepted, and low at all other times. A clean packet gives `pkt_done`=1 with the other three flags low.
- R8: Fault state is cleared when the end beat is accepted, so the next packet starts clean.
- R9: An abort on an accepted first beat of a packet raises `abort_misuse` for one cycle, one cycle after that beat. The packet is still nullified.
- R10: `abort_misuse` pulses one cycle after a cycle in which valid is high and abort is low, when the cycle before had valid high, ready low and abort high.
- R11: After reset all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| par_chk_en | input | 1 | Enables the byte parity check |
| beat_valid | input | 1 | Source has a beat on the bus |
| beat_ready | input | 1 | Sink accepts the beat |
| beat_data | input | DATA_W | Beat data |
| beat_par | input | DATA_W/8 | Per-byte odd parity sideband |
| beat_last | input | 1 | End beat of the packet |
| beat_abort | input | 1 | User abort of the current packet |
| pkt_done | output | 1 | Verdict strobe for a finished packet |
| pkt_nullify | output | 1 | Packet must be nullified |
| pkt_par_err | output | 1 | Verdict cause: parity mismatch |
| pkt_abort_err | output | 1 | Verdict cause: user abort |
| abort_misuse | output | 1 | Abort protocol violation pulse |

## Verification
On every cycle, assertions check that an abort or parity fault on an accepted end beat produces the matching verdict, that the sticky abort survives until the end beat and is cleared there, that a first-beat abort raises the misuse pulse, and that the cause flags never appear without the done strobe. Only the bench scenarios can show the parity rule across all mismatch patterns, the effect of the check enable, the ignoring of values on stalled beats, a fault carried across several beats, and clean verdicts after a faulty packet.

// File: rtl/cig_pkg.sv
package cig_pkg;

    typedef struct packed {
        logic done;
        logic nullify;
        logic par_err;
        logic abort_err;
    } verdict_t;

    localparam verdict_t VERDICT_IDLE = '{done: 1'b0, nullify: 1'b0, par_err: 1'b0, abort_err: 1'b0};

    // Sideband value that makes the byte plus its bit hold an odd count of ones
    function automatic logic odd_fill(input logic [7:0] b);
        return ~(^b);
    endfunction

endpackage

// File: rtl/cig_par_scan.sv
module cig_par_scan
    import cig_pkg::*;
#(
    parameter int NBYTES = 64
) (
    input  logic                  en,
    input  logic [NBYTES*8-1:0]   data,
    input  logic [NBYTES-1:0]     par,
    output logic                  fault
);
    logic [NBYTES-1:0] mism;

    for (genvar g = 0; g < NBYTES; g++) begin : g_byte
        assign mism[g] = (odd_fill(data[g*8 +: 8]) != par[g]);
    end

    assign fault = en & (|mism);

endmodule

// File: rtl/cig_abort_track.sv
module cig_abort_track (
    input  logic clk,
    input  logic rst,
    input  logic valid,
    input  logic ready,
    input  logic last,
    input  logic abort,
    output logic abort_hit,
    output logic misuse
);
    logic accept;
    logic in_pkt_q;
    logic sticky_q;
    logic hold_q;
    logic first_beat;

    assign accept     = valid & ready;
    assign first_beat = ~in_pkt_q;
    assign abort_hit  = sticky_q | (accept & abort);

    always_ff @(posedge clk) begin
        if (rst) begin
            in_pkt_q <= 1'b0;
            sticky_q <= 1'b0;
            hold_q   <= 1'b0;
            misuse   <= 1'b0;
        end else begin
            if (accept) begin
                in_pkt_q <= ~last;
                sticky_q <= last ? 1'b0 : (sticky_q | abort);
            end
            hold_q <= valid & ~ready & abort;
            misuse <= (accept & first_beat & abort) | (hold_q & valid & ~abort);
        end
    end

    // R4: an abort taken mid-packet stays held
    a_r4_sticky_set: assert property (@(posedge clk) disable iff (rst)
        (accept && abort && !last) |=> sticky_q);
    a_r4_sticky_hold: assert property (@(posedge clk) disable iff (rst)
        (sticky_q && !(accept && last)) |=> sticky_q);
    // R8: end beat clears the held abort
    a_r8_clear: assert property (@(posedge clk) disable iff (rst)
        (accept && last) |=> !sticky_q);
    // R9: first-beat abort flagged
    a_r9_first_abort: assert property (@(posedge clk) disable iff (rst)
        (accept && first_beat && abort) |=> misuse);

endmodule

// File: rtl/cig_verdict.sv
module cig_verdict
    import cig_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     accept,
    input  logic     last,
    input  logic     par_fault,
    input  logic     abort_hit,
    output verdict_t verdict
);
    logic     par_sticky_q;
    logic     par_hit;
    verdict_t next_v;

    assign par_hit = par_sticky_q | (accept & par_fault);

    always_comb begin
        next_v = VERDICT_IDLE;
        if (accept && last) begin
            next_v.done      = 1'b1;
            next_v.par_err   = par_hit;
            next_v.abort_err = abort_hit;
            next_v.nullify   = par_hit | abort_hit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            par_sticky_q <= 1'b0;
            verdict      <= VERDICT_IDLE;
        end else begin
            if (accept) par_sticky_q <= last ? 1'b0 : par_hit;
            verdict <= next_v;
        end
    end

    // R3: a mid-packet parity fault is held until the end beat
    a_r3_par_hold: assert property (@(posedge clk) disable iff (rst)
        (accept && par_fault && !last) |=> par_sticky_q);
    // R8: parity state cleared at the end beat
    a_r8_par_clear: assert property (@(posedge clk) disable iff (rst)
        (accept && last) |=> !par_sticky_q);

endmodule

// File: rtl/cpl_integrity_guard.sv
module cpl_integrity_guard
    import cig_pkg::*;
#(
    parameter int DATA_W = 512,
    localparam int NBYTES = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              par_chk_en,
    input  logic              beat_valid,
    input  logic              beat_ready,
    input  logic [DATA_W-1:0] beat_data,
    input  logic [NBYTES-1:0] beat_par,
    input  logic              beat_last,
    input  logic              beat_abort,
    output logic              pkt_done,
    output logic              pkt_nullify,
    output logic              pkt_par_err,
    output logic              pkt_abort_err,
    output logic              abort_misuse
);
    logic     accept;
    logic     par_fault;
    logic     abort_hit;
    verdict_t verdict;

    assign accept = beat_valid & beat_ready;

    cig_par_scan #(.NBYTES(NBYTES)) u_scan (
        .en    (par_chk_en),
        .data  (beat_data),
        .par   (beat_par),
        .fault (par_fault)
    );

    cig_abort_track u_abort (
        .clk       (clk),
        .rst       (rst),
        .valid     (beat_valid),
        .ready     (beat_ready),
        .last      (beat_last),
        .abort     (beat_abort),
        .abort_hit (abort_hit),
        .misuse    (abort_misuse)
    );

    cig_verdict u_verdict (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .last      (beat_last),
        .par_fault (par_fault),
        .abort_hit (abort_hit),
        .verdict   (verdict)
    );

    assign pkt_done      = verdict.done;
    assign pkt_nullify   = verdict.nullify;
    assign pkt_par_err   = verdict.par_err;
    assign pkt_abort_err = verdict.abort_err;

    // R5: abort on the accepted end beat nullifies
    a_r5_end_abort: assert property (@(posedge clk) disable iff (rst)
        (accept && beat_last && beat_abort) |=> (pkt_done && pkt_nullify && pkt_abort_err));
    // R1: parity fault on accepted end beat nullifies
    a_r1_end_parity: assert property (@(posedge clk) disable iff (rst)
        (accept && beat_last && par_fault) |=> (pkt_nullify && pkt_par_err));
    // R7: cause flags only together with the done strobe
    a_r7_flags_with_done: assert property (@(posedge clk) disable iff (rst)
        (pkt_nullify || pkt_par_err || pkt_abort_err) |-> pkt_done);
    // R7: no verdict without an accepted end beat
    a_r7_done_src: assert property (@(posedge clk) disable iff (rst)
        !(accept && beat_last) |=> !pkt_done);

endmodule

// File: tb/cpl_integrity_guard_test.sv
module cpl_integrity_guard_test;
    localparam int DW = 32;
    localparam int NB = DW / 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b1;
    logic valid = 1'b0, ready = 1'b0, last = 1'b0, abort = 1'b0;
    logic [DW-1:0] data = '0;
    logic [NB-1:0] par = '0;
    logic done, nul, perr, aerr, mis;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    cpl_integrity_guard #(.DATA_W(DW)) uut (
        .clk(clk), .rst(rst), .par_chk_en(en),
        .beat_valid(valid), .beat_ready(ready), .beat_data(data),
        .beat_par(par), .beat_last(last), .beat_abort(abort),
        .pkt_done(done), .pkt_nullify(nul), .pkt_par_err(perr),
        .pkt_abort_err(aerr), .abort_misuse(mis)
    );

    function automatic logic [NB-1:0] good_par(input logic [DW-1:0] d);
        logic [NB-1:0] p;
        for (int i = 0; i < NB; i++)
            p[i] = ($countones(d[i*8 +: 8]) % 2 == 0);
        return p;
    endfunction

    task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got done/nul/perr/aerr/mis=%b expected %b", tag, act, exp);
        end
    endtask

    function automatic logic [4:0] outs();
        return {done, nul, perr, aerr, mis};
    endfunction

    task automatic beat(input logic v, input logic r, input logic [DW-1:0] d,
                        input logic [NB-1:0] p, input logic l, input logic a);
        @(negedge clk);
        valid = v; ready = r; data = d; par = p; last = l; abort = a;
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        beat(1'b0, 1'b1, '0, '0, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R11 reset", outs(), 5'b00000);
        @(negedge clk);
        rst = 1'b0;
        idle();
        chk("R11 idle after reset", outs(), 5'b00000);

        // R1 sweep: all mismatch masks, several data words, single-beat packets
        for (int m = 0; m < (1 << NB); m++) begin
            for (int k = 0; k < 4; k++) begin
                logic [DW-1:0] d;
                logic bad;
                d = 32'h9E3779B9 * (k + 1) + m * 32'h01010101;
                bad = (m != 0);
                beat(1'b1, 1'b1, d, good_par(d) ^ NB'(m), 1'b1, 1'b0);
                chk("R1 parity sweep", outs(), {1'b1, bad, bad, 1'b0, 1'b0});
            end
        end

        // R2 disabled check ignores parity
        en = 1'b0;
        for (int m = 0; m < (1 << NB); m++) begin
            beat(1'b1, 1'b1, 32'h12345678 + m, NB'(m), 1'b1, 1'b0);
            chk("R2 parity disabled", outs(), 5'b10000);
        end
        en = 1'b1;

        // R3 fault on first beat carried across beats
        beat(1'b1, 1'b1, 32'hA5A5A5A5, ~good_par(32'hA5A5A5A5), 1'b0, 1'b0);
        chk("R3 mid packet no verdict", outs(), 5'b00000);
        beat(1'b1, 1'b1, 32'h00FF00FF, good_par(32'h00FF00FF), 1'b0, 1'b0);
        beat(1'b1, 1'b1, 32'h01020304, good_par(32'h01020304), 1'b1, 1'b0);
        chk("R3 carried parity fault", outs(), 5'b11100);
        // R8 next packet clean
        beat(1'b1, 1'b1, 32'h0, good_par(32'h0), 1'b1, 1'b0);
        chk("R8 clean after parity fault", outs(), 5'b10000);

        // R4 abort on second beat then dropped
        beat(1'b1, 1'b1, 32'h11, good_par(32'h11), 1'b0, 1'b0);
        beat(1'b1, 1'b1, 32'h22, good_par(32'h22), 1'b0, 1'b1);
        chk("R4 abort no early verdict", outs(), 5'b00000);
        beat(1'b1, 1'b1, 32'h33, good_par(32'h33), 1'b0, 1'b0);
        idle();
        beat(1'b1, 1'b1, 32'h44, good_par(32'h44), 1'b1, 1'b0);
        chk("R4 sticky abort", outs(), 5'b11010);
        beat(1'b1, 1'b1, 32'h55, good_par(32'h55), 1'b1, 1'b0);
        chk("R8 clean after abort", outs(), 5'b10000);

        // R5 abort on the end beat
        beat(1'b1, 1'b1, 32'h66, good_par(32'h66), 1'b0, 1'b0);
        beat(1'b1, 1'b1, 32'h77, good_par(32'h77), 1'b1, 1'b1);
        chk("R5 abort on end beat", outs(), 5'b11010);

        // R5/R1 both causes
        beat(1'b1, 1'b1, 32'h88, good_par(32'h88), 1'b0, 1'b0);
        beat(1'b1, 1'b1, 32'h99, ~good_par(32'h99), 1'b1, 1'b1);
        chk("R5 both causes", outs(), 5'b11110);

        // R6 stalled beats with bad parity are ignored
        beat(1'b1, 1'b0, 32'hDEAD, ~good_par(32'hDEAD), 1'b1, 1'b0);
        chk("R6 stalled no verdict", outs(), 5'b00000);
        beat(1'b1, 1'b1, 32'hBEEF, good_par(32'hBEEF), 1'b1, 1'b0);
        chk("R6 stalled parity ignored", outs(), 5'b10000);
        // R6 abort held on stalled beat ignored, then dropped with valid low
        beat(1'b1, 1'b1, 32'h1, good_par(32'h1), 1'b0, 1'b0);
        beat(1'b0, 1'b0, 32'h2, good_par(32'h2), 1'b0, 1'b1);
        beat(1'b1, 1'b1, 32'h3, good_par(32'h3), 1'b1, 1'b0);
        chk("R6 unaccepted abort ignored", outs(), 5'b10000);

        // R9 abort on first beat
        beat(1'b1, 1'b1, 32'h4, good_par(32'h4), 1'b0, 1'b1);
        chk("R9 first beat abort misuse", outs(), 5'b00001);
        beat(1'b1, 1'b1, 32'h5, good_par(32'h5), 1'b1, 1'b0);
        chk("R9 first beat abort nullifies", outs(), 5'b11010);

        // R10 abort dropped while stalled
        beat(1'b1, 1'b1, 32'h6, good_par(32'h6), 1'b0, 1'b0);
        beat(1'b1, 1'b0, 32'h7, good_par(32'h7), 1'b0, 1'b1);
        chk("R10 no misuse while held", outs(), 5'b00000);
        beat(1'b1, 1'b0, 32'h7, good_par(32'h7), 1'b0, 1'b0);
        chk("R10 drop while stalled", outs(), 5'b00001);
        beat(1'b1, 1'b1, 32'h7, good_par(32'h7), 1'b1, 1'b0);
        chk("R7 verdict after drop", outs(), 5'b10000);
        // R7 one-cycle pulse
        idle();
        chk("R7 pulse ends", outs(), 5'b00000);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule